// File: doc/BRIEF.md
# SMRAM Access Control Register

This block holds the byte-wide control register that governs access to system-management memory. Software reaches it through a simple configuration port: a one-cycle write strobe with a data byte, and a read-data byte that always shows the current register contents. Four control bits drive the memory decoders directly: window open, window closed, lock and global enable.

The lock bit is the security anchor. Writing a one to it clears the open bit in that same write. From then on the open bit cannot be set, the lock cannot be cleared, and the global enable bit is frozen. Only the closed bit stays writable. A system reset is the only way to release the lock. The low three bits read as a fixed constant, and the top bit reads as zero.

Top module: `smram_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x02 and all four control outputs are low.
- R2: While unlocked, a write loads bit 6 into open, bit 5 into closed, bit 4 into lock and bit 3 into global enable. A read in the following cycle returns those values.
- R3: A write that sets bit 4 (lock) also clears open in that same write, whatever bit 6 holds.
- R4: While locked, writes with bit 6 set are ignored and open reads as zero.
- R5: While locked, writing zero to bit 4 leaves the lock set.
- R6: While locked, global enable (bit 3) keeps its value across every write.
- R7: Closed (bit 5) is writable whether locked or not, including in the same write that clears open and lock.
- R8: Bits 2:0 always read as 3'b010 and bit 7 always reads as zero, regardless of the data written.
- R9: Reset releases the lock, after which open can be set and cleared again.
- R10: In a cycle without a write strobe the register contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Current register contents |
| smram_open | output | 1 | Open bit to the memory decoders |
| smram_closed | output | 1 | Closed bit to the memory decoders |
| smram_locked | output | 1 | Lock bit to the memory decoders |
| smram_global_en | output | 1 | Global enable bit to the memory decoders |

## Verification
The assertions check four things on every cycle:
- the lock never falls outside reset;
- open and lock are never high together;
- global enable holds while locked;
- the register holds in cycles without a write.

The bench sweeps every write byte in both the unlocked and locked states and compares the read-back with a value it builds itself from the bit positions. These sweeps are the only way to show that:
- each field lands in its place;
- the constant bits resist writes;
- a reset gives back write access to the open bit.

// File: rtl/smram_pkg.sv
package smram_pkg;
  localparam int REG_W     = 8;
  localparam int OPEN_POS  = 6;
  localparam int CLS_POS   = 5;
  localparam int LOCK_POS  = 4;
  localparam int GEN_POS   = 3;
  localparam int CONST_W   = 3;
  localparam logic [CONST_W-1:0] CONST_VAL = 3'b010;

  typedef struct packed {
    logic open;
    logic closed;
    logic lock;
    logic gen;
  } smram_bits_t;

  // Assemble the read-back byte from the live control bits.
  function automatic logic [REG_W-1:0] pack_rd(input smram_bits_t b);
    logic [REG_W-1:0] r;
    r = '0;
    r[OPEN_POS]        = b.open;
    r[CLS_POS]         = b.closed;
    r[LOCK_POS]        = b.lock;
    r[GEN_POS]         = b.gen;
    r[CONST_W-1:0]     = CONST_VAL;
    return r;
  endfunction

  // Next value of the open bit: cleared by any lock, writable only when unlocked.
  function automatic logic next_open(input logic cur, input logic wr,
                                     input logic wbit, input logic locked_now,
                                     input logic lock_req);
    if (locked_now || (wr && lock_req)) return 1'b0;
    if (wr) return wbit;
    return cur;
  endfunction
endpackage

// File: rtl/smram_lock_tracker.sv
module smram_lock_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic lock_req,
  output logic locked,
  output logic lock_set_evt
);
  logic lock_q;

  assign lock_set_evt = wr && lock_req && !lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else if (lock_set_evt) lock_q <= 1'b1;
  end

  assign locked = lock_q;

  // R5: the lock is sticky until reset
  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
endmodule

// File: rtl/smram_field_bank.sv
module smram_field_bank
  import smram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic [REG_W-1:0] wdata,
  input  logic locked,
  output logic open_q,
  output logic closed_q,
  output logic gen_q
);
  logic open_d;

  always_comb
    open_d = next_open(open_q, wr, wdata[OPEN_POS], locked, wdata[LOCK_POS]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      closed_q <= 1'b0;
      gen_q    <= 1'b0;
    end else begin
      open_q <= open_d;
      if (wr) closed_q <= wdata[CLS_POS];
      if (wr && !locked) gen_q <= wdata[GEN_POS];
    end
  end

  // R6: global enable frozen while locked
  assert_gen_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(gen_q));
  // R2: unlocked write setting open without lock raises open
  assert_open_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !locked && wdata[OPEN_POS] && !wdata[LOCK_POS]) |=> open_q);
endmodule

// File: rtl/smram_ctrl_reg.sv
module smram_ctrl_reg
  import smram_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             smram_open,
  output logic             smram_closed,
  output logic             smram_locked,
  output logic             smram_global_en
);
  logic        locked;
  logic        lock_set_evt;
  smram_bits_t bits;

  smram_lock_tracker u_lock (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr           (cfg_wr),
    .lock_req     (cfg_wdata[LOCK_POS]),
    .locked       (locked),
    .lock_set_evt (lock_set_evt)
  );

  smram_field_bank u_fields (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .wdata    (cfg_wdata),
    .locked   (locked),
    .open_q   (bits.open),
    .closed_q (bits.closed),
    .gen_q    (bits.gen)
  );

  assign bits.lock       = locked;
  assign cfg_rdata       = pack_rd(bits);
  assign smram_open      = bits.open;
  assign smram_closed    = bits.closed;
  assign smram_locked    = bits.lock;
  assign smram_global_en = bits.gen;

  // R3 and R4: open and lock never high together
  assert_open_vs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(smram_open && smram_locked));
  // R3: a lock-setting write leaves open clear
  assert_lock_clears_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_set_evt |=> !smram_open);
  // R10: no write, no change
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_rdata));
endmodule

// File: tb/tb_smram_ctrl_reg.sv
module tb_smram_ctrl_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       smram_open, smram_closed, smram_locked, smram_global_en;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // model state
  bit m_open, m_cls, m_lock, m_gen;

  always #2.5 clk = ~clk;

  smram_ctrl_reg dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .smram_open(smram_open), .smram_closed(smram_closed),
    .smram_locked(smram_locked), .smram_global_en(smram_global_en)
  );

  function automatic logic [7:0] model_rd();
    return (8'(m_open) << 6) + (8'(m_cls) << 5) + (8'(m_lock) << 4) +
           (8'(m_gen) << 3) + 8'd2;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic check_outs(input string req);
    check(req, {4'b0, smram_open, smram_closed, smram_locked, smram_global_en},
          {4'b0, 1'(m_open), 1'(m_cls), 1'(m_lock), 1'(m_gen)});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_open = 0; m_cls = 0; m_lock = 0; m_gen = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write(input logic [7:0] v);
    cfg_wr = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (!m_lock) begin
      m_lock = v[4];
      m_open = v[6] && !v[4];
      m_gen  = v[3];
    end
    m_cls = v[5];
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 reset value", cfg_rdata, 8'h02);
    check_outs("R1 reset outputs");

    // R2/R8: every byte from the unlocked state (lock writes re-reset after)
    for (int v = 0; v < 256; v++) begin
      write(8'(v));
      check("R2 R8 unlocked write readback", cfg_rdata, model_rd());
      check_outs("R2 outputs");
      if (v[4]) begin
        check("R3 lock clears open", {7'b0, smram_open}, 8'h00);
        do_reset();
      end
    end

    // R10: idle cycles hold
    write(8'h68);
    repeat (3) @(negedge clk);
    check("R10 hold without write", cfg_rdata, 8'h6A);

    // R3: lock with open requested in same write
    write(8'h58);
    check("R3 lock write with open bit", cfg_rdata, 8'h1A);

    // R4/R5/R6/R7/R8: sweep every byte while locked
    for (int v = 0; v < 256; v++) begin
      write(8'(v));
      check("R4 R5 R6 R7 locked write readback", cfg_rdata, model_rd());
      check_outs("R4 R6 locked outputs");
    end
    write(8'h40);
    check("R4 open ignored when locked", {7'b0, smram_open}, 8'h00);
    write(8'h00);
    check("R5 lock not released by zero", {7'b0, smram_locked}, 8'h01);
    check("R6 gen kept", {7'b0, smram_global_en}, 8'h01);

    // R7: closed with open/lock cleared in same write
    do_reset();
    write(8'h28);
    check("R7 closed and gen in clearing write", cfg_rdata, 8'h2A);

    // R9: reset releases lock; open writable again
    write(8'h10);
    check("R9 locked before reset", cfg_rdata, 8'h12);
    do_reset();
    write(8'h00);
    check("R9 open clear after reset", cfg_rdata, 8'h02);
    write(8'h40);
    check("R9 open settable after reset", cfg_rdata, 8'h42);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule